// File: doc/BRIEF.md
# Iterative Shift-Add Integer Multiplier

This block multiplies two 32-bit operands over a fixed number of clock cycles. It uses one adder that is reused in every cycle. In each cycle the lowest remaining bit of the second operand selects whether the first operand is added to a running upper accumulator. The accumulator pair then shifts one place to the right, so that each partial product lands at its proper weight.

One datapath serves three modes:
- A full unsigned product of twice the operand width.
- A full two's-complement product. The operands are sign-extended, and the partial product for the sign bit of the second operand is subtracted.
- A truncated product that returns only the low word.

A caller raises `start` for one cycle while `busy` is low. The operands and the mode are captured on that edge. When the result is ready, `done` pulses for one cycle. There is no stall path: `busy` high means "not ready", and a `start` raised then is dropped rather than queued. The result words keep their value until the next completed multiply replaces them.

Top module: `seqmul`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` and `done` are 0 and both result words are zero.
- R2: A `start` seen on a rising edge while `busy` is low is accepted, and `busy` is 1 from the next cycle on.
- R3: `done` is 1 for exactly one cycle, 32 clock edges after the accepting edge. `busy` falls on that same edge.
- R4: With mode 2'b01, the operands are read as unsigned, and `{prod_hi, prod_lo}` is their full 64-bit product.
- R5: With mode 2'b10, the operands are read as two's complement, and `{prod_hi, prod_lo}` is their full 64-bit signed product.
- R6: With mode 2'b00, `prod_lo` is the low 32 bits of the product (the same value whether signed or unsigned), and `prod_hi` is zero.
- R7: Mode 2'b11 gives the same results as mode 2'b00.
- R8: A `start` raised while `busy` is high is ignored. It produces no extra `done`, and it changes neither the timing nor the result of the multiply in progress.
- R9: Between two `done` pulses, `prod_hi` and `prod_lo` do not change.
- R10: Changes to `op_a`, `op_b` or `mode` after the accepting edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply (taken only while busy is low) |
| mode | input | 2 | 00 low word, 01 unsigned long, 10 signed long, 11 as 00 |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | A multiply is in progress; new starts are dropped |
| done | output | 1 | One-cycle pulse: the result words were just updated |
| prod_hi | output | 32 | Upper product word (zero in the truncated modes) |
| prod_lo | output | 32 | Lower product word |

## Verification
The assertions check the handshake and timing rules on every cycle:
- acceptance raises `busy`;
- `done` arrives exactly 32 busy cycles after acceptance and lasts one cycle;
- the result words stay still outside `done`;
- the upper word is zero after every truncated-mode multiply.

Only the bench's scenarios show arithmetic correctness. The bench compares results against a behavioural product across every corner operand pair and random operands in each mode. It also shows that starts and operand changes during a multiply leave the running result untouched.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  typedef enum logic [1:0] {
    MODE_LOW   = 2'b00,
    MODE_ULONG = 2'b01,
    MODE_SLONG = 2'b10,
    MODE_ALT   = 2'b11
  } mul_mode_e;

  // Signed long is the only mode needing sign extension.
  function automatic logic mode_signed(input logic [1:0] m);
    return m == MODE_SLONG;
  endfunction

  // Truncated modes: low-word result, high word forced to zero.
  function automatic logic mode_trunc(input logic [1:0] m);
    return (m != MODE_ULONG) && (m != MODE_SLONG);
  endfunction

endpackage

// File: rtl/seqmul_seq.sv
module seqmul_seq #(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic last,
  output logic done
);
  localparam int CW = $clog2(ITER + 1);

  logic [CW-1:0] cnt;

  assign accept = start & ~busy;
  assign last   = busy && (cnt == CW'(ITER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seqmul_core.sv
module seqmul_core
  import seqmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           last,
  input  logic [1:0]     mode,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           trunc_q,
  output logic [2*W-1:0] nxt_prod
);
  logic [W-1:0] mcand;
  logic [W:0]   acc_hi;   // one guard bit for carry / sign
  logic [W-1:0] acc_lo;   // remaining multiplier bits, product low bits
  logic         sgn_q;

  logic [W:0] addend, sum, nh;
  logic [W-1:0] nl;
  logic sub_now;

  // Sign-extend the multiplicand in signed mode, zero-extend otherwise.
  assign addend  = sgn_q ? {mcand[W-1], mcand} : {1'b0, mcand};
  // The sign bit of the multiplier has negative weight in signed mode.
  assign sub_now = sgn_q & last;

  always_comb begin
    if (acc_lo[0]) sum = sub_now ? (acc_hi - addend) : (acc_hi + addend);
    else           sum = acc_hi;
    nh = {sgn_q & sum[W], sum[W:1]};
    nl = {sum[0], acc_lo[W-1:1]};
  end

  assign nxt_prod = {nh[W-1:0], nl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand   <= '0;
      acc_hi  <= '0;
      acc_lo  <= '0;
      sgn_q   <= 1'b0;
      trunc_q <= 1'b1;
    end else if (load) begin
      mcand   <= a;
      acc_hi  <= '0;
      acc_lo  <= b;
      sgn_q   <= mode_signed(mode);
      trunc_q <= mode_trunc(mode);
    end else if (step) begin
      acc_hi <= nh;
      acc_lo <= nl;
    end
  end
endmodule

// File: rtl/seqmul_out.sv
module seqmul_out #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           trunc,
  input  logic [2*W-1:0] nxt_prod,
  output logic [W-1:0]   res_hi,
  output logic [W-1:0]   res_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
    end else if (capture) begin
      res_lo <= nxt_prod[W-1:0];
      res_hi <= trunc ? '0 : nxt_prod[2*W-1:W];
    end
  end
endmodule

// File: rtl/seqmul.sv
module seqmul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  logic accept, last, trunc_q;
  logic [2*W-1:0] nxt_prod;

  seqmul_seq #(.ITER(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .accept(accept), .last(last), .done(done)
  );

  seqmul_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(busy), .last(last),
    .mode(mode), .a(op_a), .b(op_b), .trunc_q(trunc_q), .nxt_prod(nxt_prod)
  );

  seqmul_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .capture(last), .trunc(trunc_q),
    .nxt_prod(nxt_prod), .res_hi(prod_hi), .res_lo(prod_lo)
  );
endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   mode,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  logic [7:0] busy_cnt;
  logic       trunc_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      trunc_lat <= 1'b0;
    end else if (start && !busy) begin
      busy_cnt  <= '0;
      trunc_lat <= (mode != 2'b01) && (mode != 2'b10);
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  // R2
  accept_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == 8'(W)) && !busy);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(prod_hi) && $stable(prod_lo)));

  // R6
  trunc_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trunc_lat) |-> (prod_hi == '0));
endmodule

bind seqmul seqmul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
);

// File: tb/test_seqmul.sv
module test_seqmul;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  seqmul #(.W(W)) i_seqmul (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_a(op_a),
    .op_b(op_b), .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit reported = 0;
  logic [2*W-1:0] exp_q[$];
  int cyc_q[$];
  string tag_q[$];
  logic [2*W-1:0] last_res = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [2*W-1:0] model(input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [1:0] m);
    logic [2*W-1:0] p;
    case (m)
      2'b01: p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      2'b10: p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
      default: begin
        p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        p = {{W{1'b0}}, p[W-1:0]};
      end
    endcase
    return p;
  endfunction

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'b01: return "R4 unsigned long";
      2'b10: return "R5 signed long";
      2'b00: return "R6 low word";
      default: return "R7 mode 11";
    endcase
  endfunction

  // Driver: issue one multiply and push its expectation.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [1:0] m);
    @(negedge clk);
    while (busy) @(negedge clk);
    op_a = a; op_b = b; mode = m; start = 1'b1;
    exp_q.push_back(model(a, b, m));
    tag_q.push_back(mtag(m));
    @(negedge clk);
    start = 1'b0;
    cyc_q.push_back(cyc);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected done", {prod_hi, prod_lo}, '0);
      end else begin
        logic [2*W-1:0] e;
        int c0;
        string t;
        e = exp_q.pop_front(); c0 = cyc_q.pop_front(); t = tag_q.pop_front();
        check({prod_hi, prod_lo} === e, t, {prod_hi, prod_lo}, e);
        check((cyc - c0) == W, "R3 latency", 64'(cyc - c0), 64'(W));
        check(busy === 1'b0, "R3 busy low at done", 64'(busy), 64'd0);
        last_res = {prod_hi, prod_lo};
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
    report();
  end

  localparam logic [W-1:0] CORNER [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                                          32'h8000_0000, 32'h7FFF_FFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 0 && done === 0, "R1 flags in reset", {busy, done}, 0);
    check({prod_hi, prod_lo} === '0, "R1 result in reset", {prod_hi, prod_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 0 && done === 0 && {prod_hi, prod_lo} === '0,
          "R1 after release", {busy, done, prod_hi, prod_lo}, 0);

    // R2: start accepted raises busy next cycle
    op_a = 32'd3; op_b = 32'd5; mode = 2'b01; start = 1'b1;
    exp_q.push_back(model(32'd3, 32'd5, 2'b01)); tag_q.push_back(mtag(2'b01));
    @(negedge clk);
    start = 1'b0; cyc_q.push_back(cyc);
    check(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    // R8/R10: starts and operand changes while busy are ignored
    repeat (4) @(negedge clk);
    start = 1'b1; op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678; mode = 2'b10;
    repeat (3) @(negedge clk);
    start = 1'b0;
    op_a = 32'h0F0F_0F0F; mode = 2'b00;
    while (busy) @(negedge clk);
    @(negedge clk);
    // R9: result held long after done
    repeat (10) @(negedge clk);
    check({prod_hi, prod_lo} === 64'd15, "R9 R10 held result",
          {prod_hi, prod_lo}, 64'd15);
    check(exp_q.size() == 0, "R8 no pending", 64'(exp_q.size()), 0);

    // small example: 2'b10 x 2'b11 sign-extended to full width
    run(32'hFFFF_FFFE, 32'hFFFF_FFFF, 2'b10);
    run(32'd2, 32'd3, 2'b00);

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(CORNER[i], CORNER[j], 2'(m));

    for (int k = 0; k < 40; k++)
      for (int m = 0; m < 4; m++)
        run($urandom(), $urandom(), 2'(m));

    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    // R9 after final result
    repeat (5) @(negedge clk);
    check({prod_hi, prod_lo} === last_res, "R9 final hold",
          {prod_hi, prod_lo}, last_res);
    report();
  end
endmodule